// File: doc/BRIEF.md
# Serial Display Command Receiver

This block is the front end of an eight-digit LED display driver. A host shifts 16-bit command words into it over three wires: a serial clock, a serial data line and a load strobe. Each word holds an address byte followed by a data byte. When the load strobe rises, the word that was shifted in most recently is written into the register that its address selects.

The register file has eight digit registers and five control registers. The control registers hold the decode mask, the brightness level, the number of scanned digits, the shutdown state and the lamp-test state. All of them drive the scanning back end directly.

A serial output returns each bit sixteen serial clocks after it entered. Several receivers can therefore be chained on a shared clock and load line. Each receiver in the chain keeps the last word that reached it. The host sends no-operation words to the receivers that it does not want to change.

The serial pins are sampled by the system clock, and their edges are found in that domain. The serial clock must therefore run several times slower than the system clock.

Top module: `display_cmd_rx`

## Requirements
- R1: While reset is asserted, all of the following are zero: every digit register, the decode mask, the brightness level, the scan limit and the serial output. In the same state the display is shut down (`displayOn`=0) and the lamp test is off (`testOn`=0).
- R2: Bits are shifted in most significant bit first on each rising serial clock edge. Of the last 16 bits, bits 15:8 form the address byte and bits 7:0 form the data byte. The word is committed when `serLoad` rises.
- R3: Address codes 1 to 8 write the full data byte to digit register 0 to 7. Digit register k appears on `digitBus[8k+7:8k]`, and the other digit registers keep their values.
- R4: The control register codes are as follows. Code 9 writes all 8 data bits to the decode mask. Code 10 writes data bits 3:0 to the brightness level. Code 11 writes data bits 2:0 to the scan limit. Code 12 writes data bit 0 to `displayOn`, where 1 means normal operation. Code 15 writes data bit 0 to `testOn`.
- R5: Bits 15:12 of the word play no part in choosing the register.
- R6: Address codes 0, 13 and 14 change no register.
- R7: No register changes unless `serLoad` rises. Shifting a complete word without a load leaves every output unchanged.
- R8: A bit that is shifted in at rising serial clock edge n appears on `serOut` after the falling serial clock edge that follows rising edge n+15.
- R9: `serOut` changes only in response to a falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial shift clock |
| serLoad | input | 1 | Commit strobe; its rising edge writes |
| serIn | input | 1 | Serial data in, MSB first |
| serOut | output | 1 | Serial data out for chaining |
| digitBus | output | DIGITS*DATA_W | Digit registers, digit k at bits 8k+7:8k |
| decodeMode | output | DATA_W | Per-digit decode mask |
| intensity | output | 4 | Brightness level |
| scanLimit | output | $clog2(DIGITS) | Index of the last scanned digit |
| displayOn | output | 1 | 1 = normal operation, 0 = shutdown |
| testOn | output | 1 | Lamp test active |

## Verification
The bench builds the block with its default parameters: 16-bit frames, eight digits and 8-bit data. The 4-bit address field therefore has exactly sixteen codes. The sweep writes every one of those codes under four different values of the unused upper nibble, so each digit register, each control register and each no-operation code is reached. The data pattern is varied so that the truncated fields and both states of the shutdown and test bits are exercised. A 32-bit stream checks the chain output at every falling edge once the delay line is full.

// File: rtl/display_cmd_pkg.sv
package display_cmd_pkg;

  localparam logic [3:0] ADR_NOP      = 4'h0;
  localparam logic [3:0] ADR_DECODE   = 4'h9;
  localparam logic [3:0] ADR_BRIGHT   = 4'hA;
  localparam logic [3:0] ADR_SCAN     = 4'hB;
  localparam logic [3:0] ADR_POWER    = 4'hC;
  localparam logic [3:0] ADR_LAMPTEST = 4'hF;

  localparam int BRIGHT_W = 4;

  // strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic shiftEdge;    // rising serial clock seen
    logic presentEdge;  // falling serial clock seen
    logic commitEdge;   // rising load seen
    logic bitIn;        // sampled serial data
  } serStrobe_t;

endpackage

// File: rtl/display_cmd_ctrl.sv
module display_cmd_ctrl
  import display_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serLoad,
  input  logic       serIn,
  output serStrobe_t strobe
);

  logic clkQ, clkPrev, loadQ, loadPrev, inQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkQ     <= 1'b0;
      clkPrev  <= 1'b0;
      loadQ    <= 1'b0;
      loadPrev <= 1'b0;
      inQ      <= 1'b0;
    end else begin
      clkQ     <= serClk;
      clkPrev  <= clkQ;
      loadQ    <= serLoad;
      loadPrev <= loadQ;
      inQ      <= serIn;
    end
  end

  always_comb begin
    strobe.shiftEdge   = clkQ & ~clkPrev;
    strobe.presentEdge = ~clkQ & clkPrev;
    strobe.commitEdge  = loadQ & ~loadPrev;
    strobe.bitIn       = inQ;
  end

endmodule

// File: rtl/display_cmd_dp.sv
module display_cmd_dp
  import display_cmd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DIGITS  = 8,
  parameter int DATA_W  = 8,
  localparam int SCAN_W = $clog2(DIGITS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  serStrobe_t               strobe,
  output logic                     serOut,
  output logic [DIGITS*DATA_W-1:0] digitBus,
  output logic [DATA_W-1:0]        decodeMode,
  output logic [BRIGHT_W-1:0]      intensity,
  output logic [SCAN_W-1:0]        scanLimit,
  output logic                     displayOn,
  output logic                     testOn
);

  localparam int ADDR_LO = DATA_W;

  logic [FRAME_W-1:0] frameReg;
  logic [3:0]         addrSel;
  logic [DATA_W-1:0]  dataByte;

  assign addrSel  = frameReg[ADDR_LO +: 4];
  assign dataByte = frameReg[DATA_W-1:0];

  // shift register and chain output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      serOut   <= 1'b0;
    end else begin
      if (strobe.shiftEdge)
        frameReg <= {frameReg[FRAME_W-2:0], strobe.bitIn};
      if (strobe.presentEdge)
        serOut <= frameReg[FRAME_W-1];
    end
  end

  // digit registers
  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [DATA_W-1:0] digitReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        digitReg <= '0;
      else if (strobe.commitEdge && addrSel == 4'(g + 1))
        digitReg <= dataByte;
    end
    assign digitBus[g*DATA_W +: DATA_W] = digitReg;
  end

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decodeMode <= '0;
      intensity  <= '0;
      scanLimit  <= '0;
      displayOn  <= 1'b0;
      testOn     <= 1'b0;
    end else if (strobe.commitEdge) begin
      case (addrSel)
        ADR_DECODE:   decodeMode <= dataByte;
        ADR_BRIGHT:   intensity  <= dataByte[BRIGHT_W-1:0];
        ADR_SCAN:     scanLimit  <= dataByte[SCAN_W-1:0];
        ADR_POWER:    displayOn  <= dataByte[0];
        ADR_LAMPTEST: testOn     <= dataByte[0];
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/display_cmd_rx.sv
module display_cmd_rx
  import display_cmd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DIGITS  = 8,
  parameter int DATA_W  = 8,
  localparam int SCAN_W = $clog2(DIGITS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serLoad,
  input  logic                     serIn,
  output logic                     serOut,
  output logic [DIGITS*DATA_W-1:0] digitBus,
  output logic [DATA_W-1:0]        decodeMode,
  output logic [BRIGHT_W-1:0]      intensity,
  output logic [SCAN_W-1:0]        scanLimit,
  output logic                     displayOn,
  output logic                     testOn
);

  serStrobe_t strobe;

  display_cmd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serLoad (serLoad),
    .serIn   (serIn),
    .strobe  (strobe)
  );

  display_cmd_dp #(
    .FRAME_W (FRAME_W),
    .DIGITS  (DIGITS),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .serOut     (serOut),
    .digitBus   (digitBus),
    .decodeMode (decodeMode),
    .intensity  (intensity),
    .scanLimit  (scanLimit),
    .displayOn  (displayOn),
    .testOn     (testOn)
  );

endmodule

// File: rtl/display_cmd_rx_chk.sv
module display_cmd_rx_chk #(
  parameter int FRAME_W = 16,
  parameter int DIGITS  = 8,
  parameter int DATA_W  = 8,
  localparam int SCAN_W = $clog2(DIGITS)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     serClk,
  input logic                     serLoad,
  input logic                     serIn,
  input logic                     serOut,
  input logic [DIGITS*DATA_W-1:0] digitBus,
  input logic [DATA_W-1:0]        decodeMode,
  input logic [3:0]               intensity,
  input logic [SCAN_W-1:0]        scanLimit,
  input logic                     displayOn,
  input logic                     testOn
);

  logic c1, c2, l1, l2, d1;
  logic [FRAME_W-1:0] shadow;
  logic riseC, fallC, commitNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c1 <= 1'b0; c2 <= 1'b0; l1 <= 1'b0; l2 <= 1'b0; d1 <= 1'b0;
      shadow <= '0;
    end else begin
      c1 <= serClk; c2 <= c1; l1 <= serLoad; l2 <= l1; d1 <= serIn;
      if (riseC) shadow <= {shadow[FRAME_W-2:0], d1};
    end
  end

  assign riseC     = c1 & ~c2;
  assign fallC     = ~c1 & c2;
  assign commitNow = l1 & ~l2;

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (digitBus == '0 && decodeMode == '0 && intensity == '0 &&
                               scanLimit == '0 && !displayOn && !testOn && !serOut);
    end
  end

  // R4
  bright_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitNow && shadow[DATA_W +: 4] == 4'hA) |=> intensity == $past(shadow[3:0]));

  // R7
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitNow |=> ($stable(digitBus) && $stable(decodeMode) && $stable(intensity) &&
                    $stable(scanLimit) && $stable(displayOn) && $stable(testOn)));

  // R8
  chain_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallC |=> serOut == $past(shadow[FRAME_W-1]));

  // R9
  chain_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fallC |=> $stable(serOut));

endmodule

bind display_cmd_rx display_cmd_rx_chk #(
  .FRAME_W (FRAME_W),
  .DIGITS  (DIGITS),
  .DATA_W  (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .serClk     (serClk),
  .serLoad    (serLoad),
  .serIn      (serIn),
  .serOut     (serOut),
  .digitBus   (digitBus),
  .decodeMode (decodeMode),
  .intensity  (intensity),
  .scanLimit  (scanLimit),
  .displayOn  (displayOn),
  .testOn     (testOn)
);

// File: tb/display_cmd_rx_tb.sv
module display_cmd_rx_tb;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serLoad = 1'b0, serIn = 1'b0;
  logic serOut, displayOn, testOn;
  logic [63:0] digitBus;
  logic [7:0]  decodeMode;
  logic [3:0]  intensity;
  logic [2:0]  scanLimit;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] expDigit [8];
  logic [7:0] expDecode;
  logic [3:0] expBright;
  logic [2:0] expScan;
  logic       expOn, expTest;

  always #5 clk = ~clk;

  display_cmd_rx u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad), .serIn(serIn),
    .serOut(serOut), .digitBus(digitBus), .decodeMode(decodeMode),
    .intensity(intensity), .scanLimit(scanLimit), .displayOn(displayOn), .testOn(testOn)
  );

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shiftBit(logic b);
    serIn = b;
    waitClk(HALF);
    serClk = 1'b1;
    waitClk(HALF);
    serClk = 1'b0;
    waitClk(HALF);
  endtask

  task automatic sendWord(logic [15:0] w);
    for (int i = 15; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    waitClk(HALF);
    serLoad = 1'b0;
    waitClk(HALF);
  endtask

  task automatic applyModel(logic [3:0] a, logic [7:0] d);
    case (a)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8: expDigit[a - 1] = d;
      4'h9: expDecode = d;
      4'hA: expBright = d[3:0];
      4'hB: expScan   = d[2:0];
      4'hC: expOn     = d[0];
      4'hF: expTest   = d[0];
      default: ;
    endcase
  endtask

  task automatic checkAll(string req);
    for (int k = 0; k < 8; k++) check(req, 32'(digitBus[k*8 +: 8]), 32'(expDigit[k]));
    check(req, 32'(decodeMode), 32'(expDecode));
    check(req, 32'(intensity), 32'(expBright));
    check(req, 32'(scanLimit), 32'(expScan));
    check(req, 32'(displayOn), 32'(expOn));
    check(req, 32'(testOn), 32'(expTest));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) expDigit[k] = '0;
    expDecode = '0; expBright = '0; expScan = '0; expOn = 1'b0; expTest = 1'b0;

    // R1: outputs during reset
    waitClk(3);
    checkAll("R1");
    check("R1", 32'(serOut), 32'h0);
    rstN = 1'b1;
    waitClk(3);

    // R2 R3 R4 R5 R6: every address code under four upper nibbles
    for (int up = 0; up < 4; up++) begin
      for (int a = 0; a < 16; a++) begin
        logic [3:0] upper = 4'((up * 5) & 15);
        logic [7:0] data  = 8'((a * 29 + up * 71 + 3) & 255);
        sendWord({upper, 4'(a), data});
        pulseLoad();
        applyModel(4'(a), data);
        if (a == 0 || a == 13 || a == 14) checkAll("R6/R5");
        else if (a >= 1 && a <= 8)      checkAll("R3/R2/R5");
        else                            checkAll("R4/R5");
      end
    end

    // R7: a full word with no load changes nothing
    sendWord(16'h0A0F);
    waitClk(HALF);
    checkAll("R7");
    pulseLoad();
    applyModel(4'hA, 8'h0F);
    checkAll("R2");

    // R8: chain output delayed by sixteen bits
    begin
      logic [31:0] pat = 32'hC3A5_1E69;
      for (int i = 0; i < 32; i++) begin
        shiftBit(pat[31 - i]);
        if (i >= 15) check("R8", 32'(serOut), 32'(pat[31 - (i - 15)]));
      end
    end
    checkAll("R7");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule